// File: doc/BRIEF.md
# Flash Interrupt Status Register

This block is the interrupt status register of a flash memory controller. It holds one master interrupt bit and four source bits that flag the completion of read, program, erase and reset operations. The controller reports each finished operation as a one-cycle pulse, tagged with the command opcode where one applies. Software reads the 16-bit value from a simple register port. It acknowledges interrupts by writing zeros to the bits it has serviced.

The master bit drives an external interrupt pin. A configuration input sets the active level of the pin. The asynchronous flavour of reset is not used here. The active-low clock-synchronous reset loads the cold default. A separate reset strobe, qualified by a reset-kind code, loads either the cold default or the warm/hot default. Some commands finish without a source of their own. Those raise only the master bit.

Top module: `flash_irq_status`

## Requirements
- R1: The read value `rd_data` places the master bit at bit 15, the read source at bit 7, the program source at bit 6, the erase source at bit 5 and the reset source at bit 4. All other bits always read 0.
- R2: When `rst_n` is low at a clock edge, or when `soft_rst` is high with `rst_kind` = 2'b00 (cold), the register becomes 16'h8080 after that edge.
- R3: When `soft_rst` is high with `rst_kind` = 2'b01 (warm), 2'b10 (hot) or 2'b11 (handled as hot), the register becomes 16'h8010 after that edge.
- R4: The read source bit sets in either of two cases: `op_done` is high with `op_code` 16'h0000 or 16'h0013, or `load_done` is high.
- R5: The program source bit sets when `op_done` is high with `op_code` 16'h0080, 16'h001A or 16'h001B.
- R6: The erase source bit sets when `erase_done` is high. The reset source bit sets when `reset_done` is high.
- R7: The master bit sets in the same edge as any source set event. It also sets when `op_done` is high with `op_code` 16'h0065, 16'h0023, 16'h0071, 16'h002A or 16'h002C. Those five opcodes set no source bit.
- R8: With `wr_en` high, each implemented bit whose `wr_data` bit is 0 is cleared. Writing 1 leaves a bit unchanged. Values written to the reserved positions have no effect.
- R9: Priority is reset first, then set events, then clearing writes. A set event and a clearing write to the same bit in the same cycle leave the bit at 1.
- R10: `irq_pin` equals `irq_pol` while the master bit is 1. It equals the inverse of `irq_pol` while the master bit is 0.
- R11: Without reset, write or set event, the register holds its value. Other opcodes have no effect. An `op_code` presented while `op_done` is low has no effect.
- R12: Every update is visible on `rd_data` right after the clock edge that takes it. Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the cold default |
| soft_rst | input | 1 | Reset strobe, default chosen by rst_kind |
| rst_kind | input | 2 | 00 cold, 01 warm, 10 hot, 11 hot |
| op_done | input | 1 | Command completion pulse qualifying op_code |
| op_code | input | 16 | Opcode of the command that completed |
| load_done | input | 1 | Buffer load or boot finished |
| erase_done | input | 1 | Erase operation finished |
| reset_done | input | 1 | Reset sequence finished |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data, 0 clears a bit |
| irq_pol | input | 1 | Active level of irq_pin |
| rd_data | output | 16 | Current register value |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The properties assume that every input is a clean level at the clock edge. They also assume that the completion pulses and the write strobe may arrive in any combination, including a set event and a clearing write in the same cycle. They expect `rst_n` to be low at the first edge, so that the register starts from a known default. The stimulus changes inputs only on falling edges. It asserts `rst_n` from time zero. It deliberately overlaps writes, set events and reset strobes to exercise the priority order, and it rotates through every listed opcode plus one unlisted opcode.

// File: rtl/flash_irq_pkg.sv
`timescale 1ns/1ps
// Package flash_irq_pkg
// Shared constants and types of the flash interrupt status register.
// Assumes a 16-bit register in which the source bits are contiguous.
package flash_irq_pkg;
    localparam int REG_W      = 16;
    localparam int OPC_W      = 16;
    localparam int SRC_N      = 4;
    localparam int SRC_LSB    = 4;   // reset source is the lowest
    localparam int MASTER_POS = 15;
    // source index: 0 reset, 1 erase, 2 program, 3 read
    localparam int SRC_RST = 0;
    localparam int SRC_ERS = 1;
    localparam int SRC_PRG = 2;
    localparam int SRC_RD  = 3;

    localparam logic [REG_W-1:0] DEF_COLD = 16'h8080;
    localparam logic [REG_W-1:0] DEF_WARM = 16'h8010;
    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << MASTER_POS) | (((REG_W'(1) << SRC_N) - 1) << SRC_LSB);

    typedef enum logic [1:0] {
        KIND_COLD = 2'b00,
        KIND_WARM = 2'b01,
        KIND_HOT  = 2'b10,
        KIND_HOT2 = 2'b11
    } rst_kind_t;

    localparam logic [OPC_W-1:0] OPC_LOAD_A  = 16'h0000;
    localparam logic [OPC_W-1:0] OPC_LOAD_B  = 16'h0013;
    localparam logic [OPC_W-1:0] OPC_PROG_A  = 16'h0080;
    localparam logic [OPC_W-1:0] OPC_PROG_B  = 16'h001A;
    localparam logic [OPC_W-1:0] OPC_PROG_C  = 16'h001B;
    localparam logic [OPC_W-1:0] OPC_MAST_A  = 16'h0065;
    localparam logic [OPC_W-1:0] OPC_MAST_B  = 16'h0023;
    localparam logic [OPC_W-1:0] OPC_MAST_C  = 16'h0071;
    localparam logic [OPC_W-1:0] OPC_MAST_D  = 16'h002A;
    localparam logic [OPC_W-1:0] OPC_MAST_E  = 16'h002C;
endpackage

// File: rtl/flash_irq_decode.sv
`timescale 1ns/1ps
// Module flash_irq_decode
// Turns completion pulses and the finished opcode into per-bit set events.
// Assumes op_code is only meaningful while op_done is high.
module flash_irq_decode
    import flash_irq_pkg::*;
(
    input  logic             op_done,
    input  logic [OPC_W-1:0] op_code,
    input  logic             load_done,
    input  logic             erase_done,
    input  logic             reset_done,
    output logic [SRC_N-1:0] src_set,
    output logic             master_only
);
    logic is_load, is_prog, is_mast;

    // Classify the finished opcode.
    always_comb begin
        is_load = (op_code == OPC_LOAD_A) || (op_code == OPC_LOAD_B);
        is_prog = (op_code == OPC_PROG_A) || (op_code == OPC_PROG_B) ||
                  (op_code == OPC_PROG_C);
        is_mast = (op_code == OPC_MAST_A) || (op_code == OPC_MAST_B) ||
                  (op_code == OPC_MAST_C) || (op_code == OPC_MAST_D) ||
                  (op_code == OPC_MAST_E);
    end

    // Route each qualified event to its source bit.
    always_comb begin
        src_set          = '0;
        src_set[SRC_RD]  = (op_done && is_load) || load_done;
        src_set[SRC_PRG] = op_done && is_prog;
        src_set[SRC_ERS] = erase_done;
        src_set[SRC_RST] = reset_done;
        master_only      = op_done && is_mast;
    end
endmodule

// File: rtl/flash_irq_cell.sv
`timescale 1ns/1ps
// Module flash_irq_cell
// One sticky status bit: reset defaults, then set, then clear-by-write.
// Assumes set_i and clr_i are single-cycle qualified strobes.
module flash_irq_cell #(
    parameter logic COLD_VAL = 1'b0,
    parameter logic WARM_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic soft_cold,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold the bit with reset > set > clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= COLD_VAL;
        else if (soft_rst) q <= soft_cold ? COLD_VAL : WARM_VAL;
        else if (set_i)    q <= 1'b1;
        else if (clr_i)    q <= 1'b0;
    end
endmodule

// File: rtl/flash_irq_pin.sv
`timescale 1ns/1ps
// Module flash_irq_pin
// Maps the master bit onto the pin level chosen by the polarity input.
// Assumes irq_pol is a static configuration level.
module flash_irq_pin (
    input  logic master_q,
    input  logic irq_pol,
    output logic irq_pin
);
    // Active level follows polarity, idle level is its inverse.
    always_comb irq_pin = master_q ? irq_pol : !irq_pol;
endmodule

// File: rtl/flash_irq_status.sv
`timescale 1ns/1ps
// Module flash_irq_status
// Interrupt status register: master bit plus four source bits, cleared by
// writing zeros. The bits are set by completion events and drive an interrupt pin.
// Assumes all inputs are synchronous to clk.
module flash_irq_status
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [1:0]       rst_kind,
    input  logic             op_done,
    input  logic [OPC_W-1:0] op_code,
    input  logic             load_done,
    input  logic             erase_done,
    input  logic             reset_done,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_pol,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_pin
);
    logic [SRC_N-1:0] src_set;
    logic [SRC_N-1:0] src_q;
    logic             master_only;
    logic             master_q;
    logic             soft_cold;

    // Cold default is chosen only by the cold kind code.
    always_comb soft_cold = (rst_kind_t'(rst_kind) == KIND_COLD);

    flash_irq_decode u_dec (
        .op_done     (op_done),
        .op_code     (op_code),
        .load_done   (load_done),
        .erase_done  (erase_done),
        .reset_done  (reset_done),
        .src_set     (src_set),
        .master_only (master_only)
    );

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        localparam int POS = SRC_LSB + i;
        flash_irq_cell #(
            .COLD_VAL (DEF_COLD[POS]),
            .WARM_VAL (DEF_WARM[POS])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .soft_cold (soft_cold),
            .set_i     (src_set[i]),
            .clr_i     (wr_en && !wr_data[POS]),
            .q         (src_q[i])
        );
    end

    flash_irq_cell #(
        .COLD_VAL (DEF_COLD[MASTER_POS]),
        .WARM_VAL (DEF_WARM[MASTER_POS])
    ) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .soft_cold (soft_cold),
        .set_i     (master_only || (|src_set)),
        .clr_i     (wr_en && !wr_data[MASTER_POS]),
        .q         (master_q)
    );

    // Assemble the read word, reserved positions forced to zero.
    always_comb begin
        rd_data = '0;
        rd_data[MASTER_POS] = master_q;
        rd_data[SRC_LSB +: SRC_N] = src_q;
    end

    flash_irq_pin u_pin (
        .master_q (master_q),
        .irq_pol  (irq_pol),
        .irq_pin  (irq_pin)
    );
endmodule

// File: rtl/flash_irq_status_chk.sv
`timescale 1ns/1ps
// Module flash_irq_status_chk
// Checker bound to flash_irq_status. It observes only the ports.
// Assumes rst_n is low at the first clock edge.
module flash_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic [1:0]  rst_kind,
    input logic        op_done,
    input logic [15:0] op_code,
    input logic        load_done,
    input logic        erase_done,
    input logic        reset_done,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        irq_pol,
    input logic [15:0] rd_data,
    input logic        irq_pin
);
    logic prog_evt;
    // Program completion as seen at the ports.
    always_comb prog_evt = op_done && (op_code == 16'h0080 ||
                           op_code == 16'h001A || op_code == 16'h001B);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 16'h7F0F) == 16'h0);
    // R2
    cold_default_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == 16'h8080);
    // R3
    warm_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && rst_kind != 2'b00 |=> rd_data == 16'h8010);
    // R8
    prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[6] && !soft_rst && !prog_evt |=> !rd_data[6]);
    // R9
    erase_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done && !soft_rst |=> rd_data[5] && rd_data[15]);
    // R7
    master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && op_code == 16'h0065 && !soft_rst |=> rd_data[15]);
    // R10
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin == (rd_data[15] ? irq_pol : !irq_pol));
    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !op_done && !load_done && !erase_done && !reset_done &&
        !soft_rst |=> $stable(rd_data));
endmodule

bind flash_irq_status flash_irq_status_chk u_chk (.*);

// File: tb/sim_flash_irq_status.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected values, the monitor compares.
module sim_flash_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [1:0]  rst_kind = 2'b00;
    logic        op_done = 1'b0;
    logic [15:0] op_code = 16'h0;
    logic        load_done = 1'b0;
    logic        erase_done = 1'b0;
    logic        reset_done = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        irq_pol = 1'b0;
    logic [15:0] rd_data;
    logic        irq_pin;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model = 16'h8080;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] exp;
        logic        pol;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = !clk;

    flash_irq_status u0 (.*);

    // Apply one cycle of stimulus and push the expected result.
    task automatic drive(input logic rn, input logic sr, input logic [1:0] kd,
                         input logic od, input logic [15:0] oc, input logic ld,
                         input logic ed, input logic rd, input logic we,
                         input logic [15:0] wd, input logic pl, input string tag);
        logic [15:0] nx;
        logic any_src;
        logic mast;
        @(negedge clk);
        rst_n = rn; soft_rst = sr; rst_kind = kd; op_done = od; op_code = oc;
        load_done = ld; erase_done = ed; reset_done = rd; wr_en = we;
        wr_data = wd; irq_pol = pl;
        nx = model;
        if (!rn) nx = 16'h8080;
        else if (sr) nx = (kd == 2'b00) ? 16'h8080 : 16'h8010;
        else begin
            if (we) nx = nx & (wd | 16'h7F0F);
            any_src = 1'b0;
            if ((od && (oc == 16'h0000 || oc == 16'h0013)) || ld) begin nx[7] = 1'b1; any_src = 1'b1; end
            if (od && (oc == 16'h0080 || oc == 16'h001A || oc == 16'h001B)) begin nx[6] = 1'b1; any_src = 1'b1; end
            if (ed) begin nx[5] = 1'b1; any_src = 1'b1; end
            if (rd) begin nx[4] = 1'b1; any_src = 1'b1; end
            mast = od && (oc == 16'h0065 || oc == 16'h0023 || oc == 16'h0071 ||
                          oc == 16'h002A || oc == 16'h002C);
            if (any_src || mast) nx[15] = 1'b1;
        end
        model = nx;
        sb.push_back('{exp: nx, pol: pl, tag: tag});
    endtask

    task automatic idle(input string tag);
        drive(1, 0, 2'b00, 0, 16'h0, 0, 0, 0, 0, 16'h0, irq_pol, tag);
    endtask

    task automatic wr(input logic [15:0] d, input string tag);
        drive(1, 0, 2'b00, 0, 16'h0, 0, 0, 0, 1, d, irq_pol, tag);
    endtask

    task automatic opc(input logic [15:0] c, input string tag);
        drive(1, 0, 2'b00, 1, c, 0, 0, 0, 0, 16'h0, irq_pol, tag);
    endtask

    // Pop and compare one expected item after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic exp_pin;
                it = sb.pop_front();
                exp_pin = it.exp[15] ? it.pol : !it.pol;
                n_chk++;
                if (rd_data !== it.exp || irq_pin !== exp_pin) begin
                    n_bad++;
                    $display("FAIL %s: rd_data=%h irq_pin=%b expected rd_data=%h irq_pin=%b",
                             it.tag, rd_data, irq_pin, it.exp, exp_pin);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        drive(0, 0, 2'b00, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, "R2 R1 cold reset value");
        idle("R11 hold after reset");
        wr(16'h0000, "R8 clear all by zeros");
        opc(16'h0000, "R4 R7 load opcode A");
        wr(16'hFFFF, "R8 writing ones no effect");
        wr(16'h7FFF, "R8 clear master only");
        opc(16'h0013, "R4 R7 load opcode B");
        wr(16'h0000, "R8 clear");
        drive(1, 0, 2'b00, 0, 16'h0, 1, 0, 0, 0, 16'h0, 0, "R4 load_done");
        wr(16'h0000, "R8 clear");
        opc(16'h001A, "R5 program opcode 1A");
        drive(1, 0, 2'b00, 1, 16'h001B, 0, 0, 0, 1, 16'hFFBF, 0, "R9 set beats clear");
        wr(16'h0000, "R8 clear");
        opc(16'h0080, "R5 program opcode 80");
        wr(16'h0000, "R8 clear");
        drive(1, 0, 2'b00, 0, 16'h0, 0, 1, 0, 0, 16'h0, 0, "R6 erase_done");
        drive(1, 0, 2'b00, 0, 16'h0, 0, 0, 1, 0, 16'h0, 1, "R6 reset_done pol high");
        wr(16'h80F0, "R8 reserved zeros ignored");
        drive(1, 0, 2'b00, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, "R10 pin pol low master set");
        wr(16'h0000, "R10 R8 pin pol low master clear");
        drive(1, 0, 2'b00, 0, 16'h0, 0, 0, 0, 0, 16'h0, 1, "R10 pin pol high master clear");
        foreach (u_mast_list[i]) begin
            opc(u_mast_list[i], "R7 master-only opcode");
            wr(16'h0000, "R8 clear");
        end
        opc(16'h0001, "R11 unlisted opcode ignored");
        drive(1, 0, 2'b00, 0, 16'h0013, 0, 0, 0, 0, 16'h0, 1, "R11 opcode without op_done");
        drive(1, 1, 2'b01, 0, 16'h0, 0, 0, 0, 0, 16'h0, 1, "R3 warm default");
        wr(16'h0000, "R8 clear");
        drive(1, 1, 2'b10, 0, 16'h0, 0, 0, 0, 0, 16'h0, 1, "R3 hot default");
        drive(1, 1, 2'b11, 0, 16'h0, 0, 1, 0, 0, 16'h0, 1, "R3 R9 reset beats set");
        drive(1, 1, 2'b00, 0, 16'h0, 0, 0, 0, 1, 16'h0, 1, "R2 R9 cold strobe beats write");
        idle("R12 R11 read has no side effect");
        idle("R12 R11 read repeated");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    logic [15:0] u_mast_list [5] = '{16'h0065, 16'h0023, 16'h0071, 16'h002A, 16'h002C};
endmodule